// File: doc/BRIEF.md
# Priority Interrupt Level Controller

This block decides which execution level a small control processor runs on. Six interrupt levels, numbered 0 to 5, sit above a main program level. The main program level runs whenever no interrupt level is in service. A lower level number means a higher priority. Level 0 handles machine checks, level 1 handles disk and diskette, and level 2 handles communications and the fixed interval timer. Levels 3 to 5 are general purpose. Each level works out of its own bank in a local register stack. The one exception is that level 0 and the main program level share bank 0.

Requests come in as one-cycle strobes and are latched as pending until they are serviced. A pending level that outranks the running level preempts it. When that happens, the processor's 4-bit condition register is saved in a slot belonging to the level being left. An end-of-level strobe returns control to the highest level still in service, or to the main program level if none is. On a return, the block presents the saved condition value for the resumed level together with a one-cycle load pulse.

Burst and base cycle-steal strobes go through the same per-cycle arbitration. A cycle-steal grant lasts one cycle and leaves the level and bank selection untouched. The controller takes exactly one action per clock. Each action is encoded as a state of a small machine:

- IDLE: nothing to do.
- RETURN: end of level.
- ENTER: a level is entered.
- BURST: a burst grant.
- BASE: a base grant.

From any state the machine moves to whichever action wins the priority check for that cycle. The outputs are decoded from the state that was just entered.

Top module: `intlvl_ctrl`

## Requirements
- R1: After reset `cur_lvl` is 6 (main program level), `bank_sel` is 0, `cs_grant` is 00 and `cr_load` is 0.
- R2: `cur_lvl` reports 0..5 for an interrupt level and 6 for the main program level. A strobe on level L with L numerically below `cur_lvl` makes `cur_lvl` equal L after the next clock edge, provided no action ranked higher is taken at that edge.
- R3: When several pending levels outrank the running level, the one with the lowest number is entered first.
- R4: A request on the running level, or on any level with a larger number, is held pending. It is entered only once the levels above it have returned.
- R5: `bank_sel` is 0 when `cur_lvl` is 0 or 6, and equals `cur_lvl` for levels 1..5.
- R6: On entering a level, `cr_in` is saved in the slot of the level being left. On a return, `cr_load` is high for one cycle and `cr_out` shows the value saved for the resumed level. `cr_out` holds that value until the next return.
- R7: A return clears the running level and resumes the lowest-numbered level still in service, or level 6 if none is.
- R8: A return strobe while at level 6 is ignored: `cur_lvl` stays 6 and `cr_load` stays 0.
- R9: Cycle-steal strobes are latched until granted. `cs_grant` bit 1 is the burst grant and bit 0 is the base grant. Each grant lasts one cycle, and burst is granted before base.
- R10: One action is taken per clock, in this priority order: return, entry of level 0, burst grant, base grant, entry of levels 1..5.
- R11: `cs_grant` never has both bits set, and `cur_lvl` does not change in a cycle with a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_req | input | 6 | Per-level request strobes, bit i = level i |
| lvl_ret | input | 1 | End-of-level return strobe |
| cs_burst_req | input | 1 | Burst cycle-steal request strobe |
| cs_base_req | input | 1 | Base cycle-steal request strobe |
| cs_grant | output | 2 | Cycle-steal grant, bit 1 burst, bit 0 base |
| cur_lvl | output | 3 | Current level, 6 = main program level |
| bank_sel | output | 3 | Register stack bank in use |
| cr_in | input | 4 | Processor condition register value |
| cr_out | output | 4 | Condition value restored on return |
| cr_load | output | 1 | One-cycle strobe to load `cr_out` |

## Verification
The bench preempts a running level in several steps, 3 then 1 then 0, while lower-ranked requests wait. It then unwinds the nesting one return at a time. A design that lost a waiting request, or resumed the wrong level, would show a wrong level, and one that indexed the save slots by the entered level would restore the wrong condition value. A return, both cycle-steal strobes and two level requests are sent in the same cycle to test the order of actions. Merging two actions into one cycle, or ranking cycle steal above level 0, would shift the level and grant sequence. A return while at the main level tests that a design which underflows its in-service set does not produce a spurious load pulse.

// File: rtl/intlvl_pkg.sv
package intlvl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RETURN,
        ST_ENTER,
        ST_BURST,
        ST_BASE
    } act_e;
endpackage

// File: rtl/intlvl_first.sv
// Lowest-index set bit finder.
module intlvl_first #(
    parameter int N = 6,
    parameter int W = 3
) (
    input  logic [N-1:0] mask,
    output logic         hit,
    output logic [W-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                hit = 1'b1;
                idx = W'(i);
            end
        end
    end
endmodule

// File: rtl/intlvl_crsave.sv
// Per-level condition register save slots.
module intlvl_crsave #(
    parameter int DEPTH = 7,
    parameter int CR_W  = 4,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [CR_W-1:0]  wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [CR_W-1:0]  rdata
);
    logic [CR_W-1:0] slot_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (we && int'(widx) < DEPTH) begin
            slot_q[widx] <= wdata;
        end
    end

    assign rdata = (int'(ridx) < DEPTH) ? slot_q[ridx] : '0;
endmodule

// File: rtl/intlvl_ctrl.sv
module intlvl_ctrl
    import intlvl_pkg::*;
#(
    parameter int NLVL = 6,
    parameter int CR_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NLVL-1:0]               lvl_req,
    input  logic                          lvl_ret,
    input  logic                          cs_burst_req,
    input  logic                          cs_base_req,
    output logic [1:0]                    cs_grant,
    output logic [$clog2(NLVL+1)-1:0]     cur_lvl,
    output logic [$clog2(NLVL+1)-1:0]     bank_sel,
    input  logic [CR_W-1:0]               cr_in,
    output logic [CR_W-1:0]               cr_out,
    output logic                          cr_load
);
    localparam int LVL_W = $clog2(NLVL + 1);
    localparam logic [LVL_W-1:0] MAIN = LVL_W'(NLVL);

    act_e            state_q, act_d;
    logic [NLVL-1:0] pend_q, insvc_q, eff, below, eff_hi, insvc_rest;
    logic            pb_q, pa_q, eff_b, eff_a;
    logic            cur_hit, pick_hit, nxt_hit;
    logic [LVL_W-1:0] cur_idx, pick_idx, nxt_idx, nxt_lvl;
    logic [CR_W-1:0] cr_out_q, saved_cr;

    // Current level: highest-priority level in service.
    intlvl_first #(.N(NLVL), .W(LVL_W)) u_cur (
        .mask(insvc_q), .hit(cur_hit), .idx(cur_idx));
    assign cur_lvl = cur_hit ? cur_idx : MAIN;

    // Level 0 shares the main program bank.
    assign bank_sel = (cur_lvl == '0 || cur_lvl == MAIN) ? '0 : cur_lvl;

    assign eff   = pend_q | lvl_req;
    assign eff_b = pb_q | cs_burst_req;
    assign eff_a = pa_q | cs_base_req;

    for (genvar g = 0; g < NLVL; g++) begin : g_below
        assign below[g] = LVL_W'(g) < cur_lvl;
    end
    assign eff_hi = eff & below;

    intlvl_first #(.N(NLVL), .W(LVL_W)) u_pick (
        .mask(eff_hi), .hit(pick_hit), .idx(pick_idx));

    // Level resumed on a return.
    assign insvc_rest = insvc_q & ~(NLVL'(1) << cur_idx);
    intlvl_first #(.N(NLVL), .W(LVL_W)) u_next (
        .mask(insvc_rest), .hit(nxt_hit), .idx(nxt_idx));
    assign nxt_lvl = nxt_hit ? nxt_idx : MAIN;

    intlvl_crsave #(.DEPTH(NLVL + 1), .CR_W(CR_W), .IDX_W(LVL_W)) u_save (
        .clk(clk), .rst_n(rst_n),
        .we(act_d == ST_ENTER), .widx(cur_lvl), .wdata(cr_in),
        .ridx(nxt_lvl), .rdata(saved_cr));

    // Action selection, fixed priority.
    always_comb begin
        if (lvl_ret && cur_hit)              act_d = ST_RETURN;
        else if (pick_hit && pick_idx == '0) act_d = ST_ENTER;
        else if (eff_b)                      act_d = ST_BURST;
        else if (eff_a)                      act_d = ST_BASE;
        else if (pick_hit)                   act_d = ST_ENTER;
        else                                 act_d = ST_IDLE;
    end

    // State register and level bookkeeping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            pend_q   <= '0;
            insvc_q  <= '0;
            pb_q     <= 1'b0;
            pa_q     <= 1'b0;
            cr_out_q <= '0;
        end else begin
            state_q <= act_d;
            pb_q    <= eff_b & (act_d != ST_BURST);
            pa_q    <= eff_a & (act_d != ST_BASE);
            if (act_d == ST_ENTER) begin
                pend_q  <= eff & ~(NLVL'(1) << pick_idx);
                insvc_q <= insvc_q | (NLVL'(1) << pick_idx);
            end else begin
                pend_q <= eff;
            end
            if (act_d == ST_RETURN) begin
                insvc_q  <= insvc_rest;
                cr_out_q <= saved_cr;
            end
        end
    end

    // Output decode.
    always_comb begin
        cs_grant = 2'b00;
        cr_load  = 1'b0;
        unique case (state_q)
            ST_BURST:          cs_grant = 2'b10;
            ST_BASE:           cs_grant = 2'b01;
            ST_RETURN:         cr_load  = 1'b1;
            ST_IDLE, ST_ENTER: ;
            default:           ;
        endcase
    end
    assign cr_out = cr_out_q;

    a_r11_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_grant));
    a_r11_grant_holds_level: assert property (@(posedge clk) disable iff (!rst_n)
        (|cs_grant) |-> $stable(cur_lvl));
    a_r6_load_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        cr_load |-> (cur_lvl > $past(cur_lvl)));
    a_r2_entry_was_requested: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_lvl < $past(cur_lvl)) |-> ((($past(eff)) >> cur_lvl) & NLVL'(1)) != '0);
    a_r8_main_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cur_lvl) == MAIN && cur_lvl == MAIN) |-> !cr_load);
endmodule

// File: tb/intlvl_ctrl_bench.sv
module intlvl_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] lvl_req = '0;
    logic       lvl_ret = 1'b0, cs_burst_req = 1'b0, cs_base_req = 1'b0;
    logic [3:0] cr_in = '0;
    logic [1:0] cs_grant;
    logic [2:0] cur_lvl, bank_sel;
    logic [3:0] cr_out;
    logic       cr_load;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;  // 250 MHz

    intlvl_ctrl u_intlvl_ctrl (
        .clk(clk), .rst_n(rst_n), .lvl_req(lvl_req), .lvl_ret(lvl_ret),
        .cs_burst_req(cs_burst_req), .cs_base_req(cs_base_req),
        .cs_grant(cs_grant), .cur_lvl(cur_lvl), .bank_sel(bank_sel),
        .cr_in(cr_in), .cr_out(cr_out), .cr_load(cr_load));

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model.
    int m_cur, m_grant, m_crout, m_load;
    int m_pend[6], m_svc[6], m_save[7];
    int m_pb, m_pa;

    function automatic int m_top();
        for (int i = 0; i < 6; i++) if (m_svc[i] != 0) return i;
        return 6;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 6; i++) begin m_pend[i] = 0; m_svc[i] = 0; end
            for (int i = 0; i < 7; i++) m_save[i] = 0;
            m_pb = 0; m_pa = 0; m_cur = 6; m_grant = 0; m_crout = 0; m_load = 0;
        end else begin
            int tgt;
            tgt = -1;
            for (int i = 0; i < 6; i++) if (lvl_req[i]) m_pend[i] = 1;
            if (cs_burst_req) m_pb = 1;
            if (cs_base_req) m_pa = 1;
            for (int i = 5; i >= 0; i--) if (m_pend[i] != 0 && i < m_cur) tgt = i;
            m_grant = 0; m_load = 0;
            if (lvl_ret && m_cur != 6) begin
                m_svc[m_cur] = 0;
                m_cur = m_top();
                m_crout = m_save[m_cur];
                m_load = 1;
            end else if (tgt == 0) begin
                m_save[m_cur] = int'(cr_in);
                m_svc[0] = 1; m_pend[0] = 0; m_cur = 0;
            end else if (m_pb != 0) begin
                m_pb = 0; m_grant = 2;
            end else if (m_pa != 0) begin
                m_pa = 0; m_grant = 1;
            end else if (tgt > 0) begin
                m_save[m_cur] = int'(cr_in);
                m_svc[tgt] = 1; m_pend[tgt] = 0; m_cur = tgt;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 cur_lvl", int'(cur_lvl), m_cur);
            chk("R5 bank_sel", int'(bank_sel), (m_cur == 0 || m_cur == 6) ? 0 : m_cur);
            chk("R9 cs_grant", int'(cs_grant), m_grant);
            chk("R6 cr_load", int'(cr_load), m_load);
            chk("R6 cr_out", int'(cr_out), m_crout);
        end
    end

    task automatic cyc(logic [5:0] req, logic ret, logic b, logic a, logic [3:0] cr);
        lvl_req = req; lvl_ret = ret; cs_burst_req = b; cs_base_req = a; cr_in = cr;
        @(negedge clk);
        lvl_req = '0; lvl_ret = 1'b0; cs_burst_req = 1'b0; cs_base_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 cur_lvl in reset", int'(cur_lvl), 6);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cur_lvl", int'(cur_lvl), 6);
        chk("R1 bank_sel", int'(bank_sel), 0);
        chk("R1 cs_grant", int'(cs_grant), 0);
        chk("R1 cr_load", int'(cr_load), 0);

        cyc(6'b001000, 0, 0, 0, 4'hA);
        chk("R2 enter 3", int'(cur_lvl), 3);
        chk("R5 bank 3", int'(bank_sel), 3);
        cyc(6'b110000, 0, 0, 0, 4'h5);
        chk("R4 lower held", int'(cur_lvl), 3);
        cyc(6'b000110, 0, 0, 0, 4'h5);
        chk("R3 lowest number wins", int'(cur_lvl), 1);
        cyc(6'b000001, 0, 0, 0, 4'h7);
        chk("R2 enter 0", int'(cur_lvl), 0);
        chk("R5 level 0 bank", int'(bank_sel), 0);
        cyc(6'b0, 1, 0, 0, 4'h0);
        chk("R7 resume 1", int'(cur_lvl), 1);
        chk("R6 load", int'(cr_load), 1);
        chk("R6 restore 1", int'(cr_out), 7);
        cyc(6'b0, 0, 0, 0, 4'h9);
        chk("R4 level 2 waits", int'(cur_lvl), 1);
        cyc(6'b0, 1, 0, 0, 4'h9);
        chk("R7 resume 3", int'(cur_lvl), 3);
        chk("R6 restore 3", int'(cr_out), 5);
        cyc(6'b0, 0, 0, 0, 4'h9);
        chk("R4 level 2 after return", int'(cur_lvl), 2);
        cyc(6'b0, 1, 0, 0, 4'h0);
        chk("R6 restore 3 again", int'(cr_out), 9);
        cyc(6'b0, 1, 0, 0, 4'h0);
        chk("R7 back to main", int'(cur_lvl), 6);
        chk("R6 restore main", int'(cr_out), 10);
        cyc(6'b0, 0, 0, 0, 4'h3);
        chk("R3 level 4 before 5", int'(cur_lvl), 4);
        cyc(6'b0, 1, 0, 0, 4'h0);
        chk("R6 restore main 3", int'(cr_out), 3);
        cyc(6'b0, 0, 0, 0, 4'h0);
        chk("R4 level 5 last", int'(cur_lvl), 5);
        cyc(6'b0, 1, 0, 0, 4'h0);
        cyc(6'b0, 0, 0, 0, 4'h0);
        cyc(6'b0, 1, 0, 0, 4'h0);
        chk("R8 main stays", int'(cur_lvl), 6);
        chk("R8 no load", int'(cr_load), 0);

        cyc(6'b0, 0, 1, 1, 4'h0);
        chk("R9 burst first", int'(cs_grant), 2);
        chk("R11 level kept", int'(cur_lvl), 6);
        cyc(6'b0, 0, 0, 0, 4'h0);
        chk("R9 base next", int'(cs_grant), 1);
        cyc(6'b0, 0, 0, 0, 4'h0);
        chk("R9 grant ends", int'(cs_grant), 0);

        cyc(6'b001000, 0, 0, 0, 4'h2);
        cyc(6'b000011, 1, 1, 1, 4'h4);
        chk("R10 return first", int'(cur_lvl), 6);
        cyc(6'b0, 0, 0, 0, 4'h4);
        chk("R10 level 0 second", int'(cur_lvl), 0);
        cyc(6'b0, 0, 0, 0, 4'h4);
        chk("R10 burst third", int'(cs_grant), 2);
        cyc(6'b0, 0, 0, 0, 4'h4);
        chk("R10 base fourth", int'(cs_grant), 1);
        cyc(6'b0, 0, 0, 0, 4'h4);
        chk("R10 level 1 held", int'(cur_lvl), 0);
        cyc(6'b0, 1, 0, 0, 4'h4);
        cyc(6'b0, 0, 0, 0, 4'h4);
        chk("R10 level 1 last", int'(cur_lvl), 1);
        cyc(6'b0, 1, 0, 0, 4'h0);
        chk("R7 final main", int'(cur_lvl), 6);
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule